// File: doc/BRIEF.md
# Coprocessor Context Frame Save/Restore Engine

This block saves and restores the context of an idle floating-point coprocessor through a 32-bit memory port. A save command writes a frame to memory. If the coprocessor has not run since its last reset, the frame is a single zero word. Otherwise it is a seven-word idle frame: a header word, five zero words and a trailer word. The frame can be written upward from the given address (postincrement) or downward from it (predecrement). In both cases the header ends up at the lowest address.

A restore command reads one header word. If the top byte of the header is zero, the frame is empty. The engine then pulses a clear strobe for the three control/status registers. It then writes a NaN pattern into every floating-point register, one register per cycle, and sets its just-reset flag. A non-empty header clears the flag. For a non-empty header the size code is checked against the known frame sizes, and the body of the frame is skipped. An unknown size code is reported. The flag is also cleared by any arithmetic or move command, which the surrounding pipeline signals on `fp_cmd_i`. The address after the operation is returned on `addr_o`.

Top module: `fpu_ctx_engine`

## Requirements
- R1: After reset `just_reset_o` is 1, and `mem_req_o`, `done_o`, `rf_we_o` and `format_error_o` are 0.
- R2: When a save starts with the just-reset flag set, it makes exactly one write, of 0x00000000 at `addr_i`. `addr_o` is then `addr_i+4` with postincrement and `addr_i` with predecrement.
- R3: When a save starts with the flag clear and postincrement selected, it writes seven words at `addr_i`, `addr_i+4`, ..., `addr_i+24`. The values are 0x1F180000, then five zeros, then 0x70000000. `addr_o` is then `addr_i+28`.
- R4: When a save starts with the flag clear and predecrement selected, it writes 0x70000000 at `addr_i`, zeros at `addr_i-4` down to `addr_i-20`, and 0x1F180000 at `addr_i-24`. `addr_o` is then `addr_i-24`.
- R5: `mem_req_o`, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` stay stable until `mem_ack_i` is sampled high. Each acknowledge completes exactly one access.
- R6: A restore whose header has bits 31:24 equal to zero is an empty frame. The low 24 bits of such a header do not matter. The engine pulses `ctl_clear_o` once. It then writes registers 0..N-1 in order on consecutive cycles, each with 0x7FFF_FFFFFFFFFFFFFFFF (sign 0, exponent all ones, mantissa all ones), and it sets `just_reset_o`. `addr_o` is `addr_i+4` with postincrement and `addr_i` otherwise.
- R7: A restore whose header has a nonzero top byte clears `just_reset_o`.
- R8: For a non-empty header, a size code in bits 23:16 of 0x18, 0x38 or 0xB4 is a known frame. With postincrement, `addr_o` is `addr_i + code + 4`; otherwise it is `addr_i`. `format_error_o` stays 0.
- R9: For a non-empty header, any other size code raises `format_error_o` in the same cycle as `done_o`, and `addr_o` equals `addr_i`.
- R10: A pulse on `fp_cmd_i` clears `just_reset_o`. A save that follows writes the seven-word idle frame.
- R11: `done_o` is high for exactly one cycle when an operation ends. A `start_i` while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| save_i | input | 1 | 1 = save frame, 0 = restore frame |
| post_inc_i | input | 1 | 1 = postincrement addressing, 0 = predecrement (save) or fixed address (restore) |
| addr_i | input | AW | Starting address |
| fp_cmd_i | input | 1 | An arithmetic or move command executed; clears the just-reset flag |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Access acknowledge |
| addr_o | output | AW | Address after the operation, valid from `done_o` |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| format_error_o | output | 1 | Unknown frame size code, pulses with `done_o` |
| ctl_clear_o | output | 1 | Clear strobe for the control/status registers |
| rf_we_o | output | 1 | Register file write enable |
| rf_idx_o | output | $clog2(NUM_FP) | Register file index |
| rf_data_o | output | 1+EXP_W+MAN_W | Register file write data (NaN fill) |
| just_reset_o | output | 1 | Just-reset flag |

## Verification
The assertions assume that the memory side raises `mem_ack_i` only while a request is pending. They also assume that read data is meaningful only in the acknowledge cycle, and that `start_i` is a single-cycle pulse.

The bench's memory responder acknowledges only a pending request. It varies the wait from zero to two cycles so that request holding is exercised. It drives header data only with the acknowledge. The driver pulses `start_i` for one cycle at a time, and it also issues one deliberately early `start_i` in the middle of a save to show that the command is ignored.

// File: rtl/fpu_ctx_pkg.sv
package fpu_ctx_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned IDLE_WORDS = 7;
  localparam logic [WORD_W-1:0] IDLE_HDR  = 32'h1F18_0000;
  localparam logic [WORD_W-1:0] IDLE_TAIL = 32'h7000_0000;
  localparam logic [7:0] SZ_SMALL = 8'h18;
  localparam logic [7:0] SZ_MID   = 8'h38;
  localparam logic [7:0] SZ_LARGE = 8'hB4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAVE,
    ST_HDR,
    ST_FILL
  } ctx_state_e;
endpackage

// File: rtl/fpu_ctx_frame_rom.sv
module fpu_ctx_frame_rom
  import fpu_ctx_pkg::*;
(
  input  logic [2:0]        pos_i,
  input  logic              null_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    word_o = '0;
    if (!null_i) begin
      if (pos_i == 3'd0) word_o = IDLE_HDR;
      else if (pos_i == 3'(IDLE_WORDS - 1)) word_o = IDLE_TAIL;
    end
  end
endmodule

// File: rtl/fpu_ctx_hdr_decode.sv
module fpu_ctx_hdr_decode
  import fpu_ctx_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [WORD_W-1:0] hdr_i,
  output logic              null_o,
  output logic              known_o,
  output logic [AW-1:0]     skip_o
);
  logic [7:0] code;
  assign code   = hdr_i[23:16];
  assign null_o = (hdr_i[31:24] == 8'h00);
  assign known_o = (code == SZ_SMALL) || (code == SZ_MID) || (code == SZ_LARGE);
  assign skip_o = {{(AW-8){1'b0}}, code};
endmodule

// File: rtl/fpu_ctx_seq.sv
module fpu_ctx_seq
  import fpu_ctx_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned NUM_FP = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      save_i,
  input  logic                      post_inc_i,
  input  logic [AW-1:0]             addr_i,
  input  logic                      fp_cmd_i,
  input  logic                      mem_ack_i,
  input  logic                      hdr_null_i,
  input  logic                      hdr_known_i,
  input  logic [AW-1:0]             hdr_skip_i,
  output logic                      mem_req_o,
  output logic                      mem_we_o,
  output logic [AW-1:0]             mem_addr_o,
  output logic [2:0]                word_pos_o,
  output logic                      null_frame_o,
  output logic [AW-1:0]             addr_o,
  output logic                      done_o,
  output logic                      format_error_o,
  output logic                      ctl_clear_o,
  output logic                      rf_we_o,
  output logic [$clog2(NUM_FP)-1:0] rf_idx_o,
  output logic                      just_reset_o
);
  localparam int unsigned FP_IDX_W = $clog2(NUM_FP);
  localparam int unsigned CNT_MAX  = (NUM_FP > IDLE_WORDS) ? NUM_FP : IDLE_WORDS;
  localparam int unsigned CNT_W    = $clog2(CNT_MAX);

  ctx_state_e       state_q;
  logic [AW-1:0]    base_q, addr_q;
  logic [CNT_W-1:0] cnt_q, last_word;
  logic             inc_q, null_q, done_q, ferr_q, clr_q, jr_q;
  logic [AW-1:0]    off, next_addr;

  assign off       = {{(AW-CNT_W-2){1'b0}}, cnt_q, 2'b00};
  assign next_addr = inc_q ? base_q + off : base_q - off;
  assign last_word = null_q ? '0 : CNT_W'(IDLE_WORDS - 1);

  assign mem_req_o    = (state_q == ST_SAVE) || (state_q == ST_HDR);
  assign mem_we_o     = (state_q == ST_SAVE);
  assign mem_addr_o   = next_addr;
  assign word_pos_o   = inc_q ? 3'(cnt_q) : 3'(CNT_W'(IDLE_WORDS - 1) - cnt_q);
  assign null_frame_o = null_q;
  assign rf_we_o      = (state_q == ST_FILL);
  assign rf_idx_o     = cnt_q[FP_IDX_W-1:0];
  assign addr_o       = addr_q;
  assign done_o       = done_q;
  assign format_error_o = ferr_q;
  assign ctl_clear_o  = clr_q;
  assign just_reset_o = jr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      inc_q   <= 1'b0;
      null_q  <= 1'b0;
      done_q  <= 1'b0;
      ferr_q  <= 1'b0;
      clr_q   <= 1'b0;
      jr_q    <= 1'b1;
    end else begin
      done_q <= 1'b0;
      ferr_q <= 1'b0;
      clr_q  <= 1'b0;
      if (fp_cmd_i) jr_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          base_q <= addr_i;
          inc_q  <= post_inc_i;
          cnt_q  <= '0;
          null_q <= jr_q;
          state_q <= save_i ? ST_SAVE : ST_HDR;
        end
        ST_SAVE: if (mem_ack_i) begin
          if (cnt_q == last_word) begin
            done_q  <= 1'b1;
            addr_q  <= inc_q ? next_addr + AW'(4) : next_addr;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HDR: if (mem_ack_i) begin
          if (hdr_null_i) begin
            jr_q    <= 1'b1;
            clr_q   <= 1'b1;
            cnt_q   <= '0;
            addr_q  <= inc_q ? base_q + AW'(4) : base_q;
            state_q <= ST_FILL;
          end else begin
            jr_q    <= 1'b0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
            if (hdr_known_i) begin
              addr_q <= inc_q ? base_q + hdr_skip_i + AW'(4) : base_q;
            end else begin
              ferr_q <= 1'b1;
              addr_q <= base_q;
            end
          end
        end
        ST_FILL: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(NUM_FP - 1)) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  ferr_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    format_error_o |-> done_o);

  // R6
  clr_then_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_clear_o |-> rf_we_o && rf_idx_o == '0 && just_reset_o);

  // R6
  fill_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o && rf_idx_o != FP_IDX_W'(NUM_FP - 1) |=> rf_we_o && rf_idx_o == $past(rf_idx_o) + 1'b1);

  // R5
  no_mem_in_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> !mem_req_o);
endmodule

// File: rtl/fpu_ctx_engine.sv
module fpu_ctx_engine
  import fpu_ctx_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned NUM_FP = 8,
  parameter int unsigned EXP_W  = 15,
  parameter int unsigned MAN_W  = 64
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        save_i,
  input  logic                        post_inc_i,
  input  logic [AW-1:0]               addr_i,
  input  logic                        fp_cmd_i,
  output logic                        mem_req_o,
  output logic                        mem_we_o,
  output logic [AW-1:0]               mem_addr_o,
  output logic [WORD_W-1:0]           mem_wdata_o,
  input  logic [WORD_W-1:0]           mem_rdata_i,
  input  logic                        mem_ack_i,
  output logic [AW-1:0]               addr_o,
  output logic                        done_o,
  output logic                        format_error_o,
  output logic                        ctl_clear_o,
  output logic                        rf_we_o,
  output logic [$clog2(NUM_FP)-1:0]   rf_idx_o,
  output logic [EXP_W+MAN_W:0]        rf_data_o,
  output logic                        just_reset_o
);
  logic          hdr_null, hdr_known, null_frame;
  logic [AW-1:0] hdr_skip;
  logic [2:0]    word_pos;

  // positive quiet NaN: exponent and mantissa all ones
  assign rf_data_o = {1'b0, {EXP_W{1'b1}}, {MAN_W{1'b1}}};

  fpu_ctx_hdr_decode #(.AW(AW)) u_dec (
    .hdr_i  (mem_rdata_i),
    .null_o (hdr_null),
    .known_o(hdr_known),
    .skip_o (hdr_skip)
  );

  fpu_ctx_frame_rom u_rom (
    .pos_i (word_pos),
    .null_i(null_frame),
    .word_o(mem_wdata_o)
  );

  fpu_ctx_seq #(.AW(AW), .NUM_FP(NUM_FP)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .save_i        (save_i),
    .post_inc_i    (post_inc_i),
    .addr_i        (addr_i),
    .fp_cmd_i      (fp_cmd_i),
    .mem_ack_i     (mem_ack_i),
    .hdr_null_i    (hdr_null),
    .hdr_known_i   (hdr_known),
    .hdr_skip_i    (hdr_skip),
    .mem_req_o     (mem_req_o),
    .mem_we_o      (mem_we_o),
    .mem_addr_o    (mem_addr_o),
    .word_pos_o    (word_pos),
    .null_frame_o  (null_frame),
    .addr_o        (addr_o),
    .done_o        (done_o),
    .format_error_o(format_error_o),
    .ctl_clear_o   (ctl_clear_o),
    .rf_we_o       (rf_we_o),
    .rf_idx_o      (rf_idx_o),
    .just_reset_o  (just_reset_o)
  );

  // R5
  wdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && !mem_ack_i |=> $stable(mem_wdata_o));
endmodule

// File: tb/fpu_ctx_engine_bench.sv
module fpu_ctx_engine_bench;
  typedef struct packed {
    logic        we;
    logic [31:0] a;
    logic [31:0] d;
  } acc_t;

  localparam logic [79:0] NAN_FILL = 80'h7FFF_FFFF_FFFF_FFFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, save = 1'b0, post_inc = 1'b0, fp_cmd = 1'b0;
  logic [31:0] addr = '0, rdata = '0;
  logic ack = 1'b0;
  logic mem_req, mem_we, done, ferr, ctl_clear, rf_we, jr;
  logic [31:0] mem_addr, mem_wdata, addr_out;
  logic [2:0]  rf_idx;
  logic [79:0] rf_data;

  int n_vec = 0, n_bad = 0;
  int fill_idx = 0, clr_cnt = 0, lat = 0;
  bit jr_model = 1'b1;
  logic [31:0] hdr_word = '0;
  acc_t exp_q[$];

  always #4 clk = ~clk;

  fpu_ctx_engine u_fpu_ctx_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .save_i(save), .post_inc_i(post_inc),
    .addr_i(addr), .fp_cmd_i(fp_cmd), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(rdata), .mem_ack_i(ack),
    .addr_o(addr_out), .done_o(done), .format_error_o(ferr), .ctl_clear_o(ctl_clear),
    .rf_we_o(rf_we), .rf_idx_o(rf_idx), .rf_data_o(rf_data), .just_reset_o(jr)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [79:0] act, input logic [79:0] expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, expv);
    end
  endtask

  // scoreboard monitor / memory responder
  initial begin
    @(negedge clk);
    forever begin
      if (mem_req) begin
        acc_t e;
        logic [31:0] a0;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11", "unexpected access", {47'd0, mem_we, mem_addr}, '0);
          e = '0;
        end else begin
          e = exp_q.pop_front();
          chk(mem_we == e.we, "R5", "access kind", 80'(mem_we), 80'(e.we));
          chk(mem_addr == e.a, "R5", "access addr", 80'(mem_addr), 80'(e.a));
          if (e.we) chk(mem_wdata == e.d, "R3", "write data", 80'(mem_wdata), 80'(e.d));
        end
        a0 = mem_addr;
        for (int w = 0; w < lat; w++) begin
          @(negedge clk);
          chk(mem_req && mem_addr == a0, "R5", "request held", 80'(mem_addr), 80'(a0));
        end
        lat = (lat + 1) % 3;
        ack = 1'b1;
        rdata = hdr_word;
        @(negedge clk);
        ack = 1'b0;
        rdata = '0;
      end else begin
        @(negedge clk);
      end
    end
  end

  always @(negedge clk) begin
    if (rf_we) begin
      chk(rf_idx == 3'(fill_idx), "R6", "fill index", 80'(rf_idx), 80'(fill_idx));
      chk(rf_data == NAN_FILL, "R6", "fill data", rf_data, NAN_FILL);
      fill_idx++;
    end
    if (ctl_clear) clr_cnt++;
  end

  task automatic wait_done(output bit got);
    got = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done) begin got = 1'b1; break; end
    end
  endtask

  task automatic run_op(input bit sv, input bit inc, input logic [31:0] a,
                        input logic [31:0] hdr, input logic [31:0] exp_addr,
                        input bit exp_ferr, input bit poke, input string rq);
    bit got;
    bit is_null;
    is_null = 1'b0;
    fill_idx = 0;
    clr_cnt = 0;
    if (sv) begin
      if (jr_model) exp_q.push_back('{1'b1, a, 32'h0});
      else
        for (int k = 0; k < 7; k++) begin
          logic [31:0] d;
          if (inc) d = (k == 0) ? 32'h1F18_0000 : (k == 6) ? 32'h7000_0000 : 32'h0;
          else     d = (k == 0) ? 32'h7000_0000 : (k == 6) ? 32'h1F18_0000 : 32'h0;
          exp_q.push_back('{1'b1, inc ? a + 32'(4*k) : a - 32'(4*k), d});
        end
    end else begin
      hdr_word = hdr;
      is_null = (hdr[31:24] == 8'h00);
      exp_q.push_back('{1'b0, a, 32'h0});
      jr_model = is_null;
    end
    save = sv; post_inc = inc; addr = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      save = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done(got);
    chk(got, rq, "done seen", 80'(got), 80'd1);
    chk(addr_out == exp_addr, rq, "addr_o", 80'(addr_out), 80'(exp_addr));
    chk(ferr == exp_ferr, rq, "format_error", 80'(ferr), 80'(exp_ferr));
    chk(exp_q.size() == 0, rq, "all accesses made", 80'(exp_q.size()), 80'd0);
    chk(jr == jr_model, rq, "just_reset", 80'(jr), 80'(jr_model));
    if (!sv) begin
      chk(fill_idx == (is_null ? 8 : 0), "R6", "fill count", 80'(fill_idx), 80'(is_null ? 8 : 0));
      chk(clr_cnt == (is_null ? 1 : 0), "R6", "ctl clear count", 80'(clr_cnt), 80'(is_null ? 1 : 0));
    end
    @(negedge clk);
    chk(!done, "R11", "done one cycle", 80'(done), 80'd0);
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(jr == 1'b1, "R1", "just_reset after reset", 80'(jr), 80'd1);
    chk(!mem_req && !done && !rf_we && !ferr, "R1", "idle outputs",
        80'({mem_req, done, rf_we, ferr}), 80'd0);
    // R2
    run_op(1, 1, 32'h0000_1000, '0, 32'h0000_1004, 0, 0, "R2");
    run_op(1, 0, 32'h0000_2000, '0, 32'h0000_2000, 0, 0, "R2");
    // R10
    fp_cmd = 1'b1;
    @(negedge clk);
    fp_cmd = 1'b0;
    jr_model = 1'b0;
    chk(jr == 1'b0, "R10", "fp command clears flag", 80'(jr), 80'd0);
    // R3 with ignored start (R11)
    run_op(1, 1, 32'h0000_3000, '0, 32'h0000_301C, 0, 1, "R3");
    // R4
    run_op(1, 0, 32'h0000_4100, '0, 32'h0000_40E8, 0, 0, "R4");
    // R8
    run_op(0, 1, 32'h0000_5000, 32'h1F18_0000, 32'h0000_501C, 0, 0, "R8");
    run_op(0, 0, 32'h0000_5100, 32'h1F38_0000, 32'h0000_5100, 0, 0, "R8");
    run_op(0, 1, 32'h0000_5200, 32'h01B4_0000, 32'h0000_52B8, 0, 0, "R8");
    run_op(0, 1, 32'h0000_5300, 32'h4138_ABCD, 32'h0000_533C, 0, 0, "R8");
    // R6
    run_op(0, 1, 32'h0000_6000, 32'h0000_0000, 32'h0000_6004, 0, 0, "R6");
    run_op(1, 1, 32'h0000_6100, '0, 32'h0000_6104, 0, 0, "R2");
    // R7
    run_op(0, 0, 32'h0000_7000, 32'h1F18_0000, 32'h0000_7000, 0, 0, "R7");
    run_op(1, 0, 32'h0000_7100, '0, 32'h0000_70E8, 0, 0, "R10");
    // R6 low bits ignored
    run_op(0, 0, 32'h0000_8000, 32'h00FF_1234, 32'h0000_8000, 0, 0, "R6");
    // R9 also clears flag (R7)
    run_op(0, 1, 32'h0000_9000, 32'h1F55_0000, 32'h0000_9000, 1, 0, "R9");
    run_op(0, 0, 32'h0000_9100, 32'h0F00_0000, 32'h0000_9100, 1, 0, "R9");
    run_op(1, 1, 32'h0000_A000, '0, 32'h0000_A01C, 0, 0, "R3");
    repeat (4) @(negedge clk);
    chk(!mem_req && !done, "R11", "quiet after ops", 80'({mem_req, done}), 80'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule